// File: doc/BRIEF.md
# Write-Protected Two-Wire Configuration Register

This block is a two-wire serial target that holds a five-bit configuration word on behalf of a
slower non-volatile store. A controller addresses it at a fixed seven-bit address and moves exactly one data
byte per transfer. A write stores the byte's low five bits. A read returns the stored word, with three zero bits above it. The stored word is driven straight out on a five-bit
port. Bit 4 is the single latched-style bit, and bits 3 to 0 are the four multiplexed bits (bit 0 is the
first of them, bit 3 the last). Other logic on the chip uses these bits.

SCL and SDA are sampled with the system clock. Each line passes through a two-flop synchronizer
and a three-sample majority vote. START and STOP are found from SDA edges while SCL is high, and the
block pulls SDA low through an open-drain enable. A write-protect input blocks writes. After every
accepted write, a parameterised busy window stands in for the non-volatile programming time. During
that window the target does not acknowledge its own address.

Top module: `cfgsw_i2c_target`

## Requirements
- R1: The target acknowledges only the address byte whose upper seven bits are 1001110 (0x4E), the least significant bit being R/W (0 = write, 1 = read); any other address is not acknowledged and the transfer has no effect.
- R2: In a write, the data byte is acknowledged and its bits 4:0 appear on `cfg_o` (bit 4 = non-multiplexed bit, bits 3:0 = multiplexed bits) in the cycle after the acknowledge clock ends.
- R3: A read returns, most significant bit first, the byte {3'b000, cfg_o}.
- R4: With write-protect high at the end of the data byte, the data byte is not acknowledged and `cfg_o` keeps its value.
- R5: A write data byte with any of bits 7:5 set is not acknowledged and `cfg_o` keeps its value.
- R6: After reset `cfg_o` is 0 and SDA is released.
- R7: For BUSY_CYCLES clock cycles after an accepted write, the target does not acknowledge its address; once the window has passed it acknowledges again.
- R8: A START or STOP in the middle of a byte abandons the transfer: a repeated START restarts address reception, and a STOP inside a write data byte leaves `cfg_o` unchanged.
- R9: A SCL pulse lasting one system clock cycle is filtered out and does not count as a bit.
- R10: The target changes its SDA drive from released to pulled only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| wp_i | input | 1 | Write protect, 1 blocks writes |
| cfg_o | output | 5 | Stored configuration word |

## Verification
A change on SCL or SDA reaches the bus engine about six system clocks after it happens: two synchronizer flops, two vote-history flops, the registered vote and the edge compare. The acknowledge or read-data drive on SDA therefore settles about six cycles after an SCL falling edge. The bench drives each SCL phase for at least twenty cycles and samples SDA in the middle of the SCL high phase, so every sample lands well after that settling point. `cfg_o` updates one cycle after the commit at the end of the acknowledge clock, and the bench reads it only after the closing STOP. The busy window counts BUSY_CYCLES from that commit, so the bench probes it with a transfer issued right after the write and confirms recovery after a wait longer than the window.

// File: rtl/cfgsw_pkg.sv
package cfgsw_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CFG_W  = 5;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned CNT_W  = 4;
  localparam logic [ADDR_W-1:0] DEV_ADDR = 7'b1001110;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_ADDR,
    BS_AACK,
    BS_WR,
    BS_DACK,
    BS_RD,
    BS_SKIP
  } bus_st_e;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  function automatic logic addr_hits(input logic [BYTE_W-1:0] b, input logic busy);
    return (b[BYTE_W-1:1] == DEV_ADDR) && !busy;
  endfunction

  function automatic logic write_allowed(input logic [BYTE_W-1:0] b, input logic wp);
    return (b[BYTE_W-1:CFG_W] == '0) && !wp;
  endfunction

  function automatic logic [BYTE_W-1:0] read_byte(input logic [CFG_W-1:0] r);
    return {{(BYTE_W-CFG_W){1'b0}}, r};
  endfunction
endpackage

// File: rtl/cfgsw_line_filter.sv
module cfgsw_line_filter
  import cfgsw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        IDLE_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             hist_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= {SYNC_STAGES{IDLE_LEVEL}};
      hist_q  <= {3{IDLE_LEVEL}};
      level_o <= IDLE_LEVEL;
      prev_q  <= IDLE_LEVEL;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q  <= {hist_q[1:0], sync_q[SYNC_STAGES-1]};
      level_o <= maj3(hist_q);
      prev_q  <= level_o;
    end
  end

  assign rise_o = level_o & ~prev_q;
  assign fall_o = ~level_o & prev_q;
endmodule

// File: rtl/cfgsw_bus_fsm.sv
module cfgsw_bus_fsm
  import cfgsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic              busy_i,
  input  logic              wp_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              sda_pull_o,
  output logic              ev_start_o,
  output logic              ev_stop_o,
  output logic              addr_hit_o,
  output logic              commit_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  bus_st_e           state_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] tx_q;
  logic              rw_q;
  logic              byte_done;

  assign ev_start_o = scl_lvl & sda_fall;
  assign ev_stop_o  = scl_lvl & sda_rise;
  assign byte_done  = scl_fall && (bitcnt_q == CNT_W'(BYTE_W));
  assign addr_hit_o = (state_q == BS_ADDR) && byte_done && addr_hits(shreg_q, busy_i);
  assign commit_o   = (state_q == BS_DACK) && scl_fall;
  assign wr_data_o  = shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= BS_IDLE;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (ev_start_o) begin
      state_q    <= BS_ADDR;
      bitcnt_q   <= '0;
      sda_pull_o <= 1'b0;
    end else if (ev_stop_o) begin
      state_q    <= BS_IDLE;
      sda_pull_o <= 1'b0;
    end else begin
      case (state_q)
        BS_ADDR, BS_WR: begin
          if (scl_rise) begin
            shreg_q  <= {shreg_q[BYTE_W-2:0], sda_lvl};
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (byte_done) begin
            if (state_q == BS_ADDR) begin
              if (addr_hit_o) begin
                state_q    <= BS_AACK;
                rw_q       <= shreg_q[0];
                sda_pull_o <= 1'b1;
              end else begin
                state_q <= BS_SKIP;
              end
            end else if (write_allowed(shreg_q, wp_i)) begin
              state_q    <= BS_DACK;
              sda_pull_o <= 1'b1;
            end else begin
              state_q <= BS_SKIP;
            end
          end
        end
        BS_AACK: begin
          if (scl_fall) begin
            bitcnt_q <= '0;
            if (rw_q) begin
              state_q    <= BS_RD;
              tx_q       <= read_byte(cfg_i);
              sda_pull_o <= ~read_byte(cfg_i)[BYTE_W-1];
            end else begin
              state_q    <= BS_WR;
              sda_pull_o <= 1'b0;
            end
          end
        end
        BS_DACK: begin
          if (scl_fall) begin
            state_q    <= BS_SKIP;
            sda_pull_o <= 1'b0;
          end
        end
        BS_RD: begin
          if (scl_fall) begin
            if (bitcnt_q == CNT_W'(BYTE_W-1)) begin
              state_q    <= BS_SKIP;
              sda_pull_o <= 1'b0;
            end else begin
              tx_q       <= {tx_q[BYTE_W-2:0], 1'b0};
              sda_pull_o <= ~tx_q[BYTE_W-2];
              bitcnt_q   <= bitcnt_q + 1'b1;
            end
          end
        end
        default: sda_pull_o <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cfgsw_store.sv
module cfgsw_store
  import cfgsw_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 1500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [CFG_W-1:0] data_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             busy_o
);
  localparam int unsigned BW = $clog2(BUSY_CYCLES + 1);
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o <= '0;
      cnt_q <= '0;
    end else if (commit_i) begin
      cfg_o <= data_i;
      cnt_q <= BW'(BUSY_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/cfgsw_i2c_target.sv
module cfgsw_i2c_target
  import cfgsw_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 1500000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic             wp_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic              scl_f, scl_rise, scl_fall;
  logic              sda_f, sda_rise, sda_fall;
  logic              ev_start, ev_stop, addr_hit, commit, busy;
  logic [BYTE_W-1:0] commit_data;
  logic [1:0]        wp_sync_q;
  logic              wp_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_sync_q <= 2'b11;
    else        wp_sync_q <= {wp_sync_q[0], wp_i};
  end
  assign wp_s = wp_sync_q[1];

  cfgsw_line_filter #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_f), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  cfgsw_line_filter #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_f), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  cfgsw_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_f), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_f), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .busy_i(busy), .wp_i(wp_s), .cfg_i(cfg_o),
    .sda_pull_o(sda_pull_o), .ev_start_o(ev_start), .ev_stop_o(ev_stop),
    .addr_hit_o(addr_hit), .commit_o(commit), .wr_data_o(commit_data)
  );

  cfgsw_store #(.BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .commit_i(commit),
    .data_i(commit_data[CFG_W-1:0]), .cfg_o(cfg_o), .busy_o(busy)
  );
endmodule

// File: rtl/cfgsw_checker.sv
module cfgsw_checker
  import cfgsw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              sda_pull,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              addr_hit,
  input logic              commit,
  input logic [BYTE_W-1:0] commit_data,
  input logic              busy,
  input logic              wp_s,
  input logic [CFG_W-1:0]  cfg
);
  AST_ADDR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> !busy);                                             // R7
  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);                                                // R7
  AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> cfg == $past(commit_data[CFG_W-1:0]));                // R2
  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg));                                       // R8
  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !wp_s);                                               // R4
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> commit_data[BYTE_W-1:CFG_W] == '0);                   // R5
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_f);                                     // R10
  AST_EVENT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start || ev_stop) |=> !sda_pull);                            // R8
endmodule

bind cfgsw_i2c_target cfgsw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_pull(sda_pull_o),
  .ev_start(ev_start), .ev_stop(ev_stop), .addr_hit(addr_hit),
  .commit(commit), .commit_data(commit_data), .busy(busy),
  .wp_s(wp_s), .cfg(cfg_o)
);

// File: tb/tb_cfgsw_i2c_target.sv
module tb_cfgsw_i2c_target;
  localparam int BUSY = 2000;
  localparam int Q    = 10;
  localparam int NV   = 12;

  // {req[3:0], rw, addr7, data/expected read, wp, exp_aack, exp_dack, exp_cfg[4:0]}
  localparam logic [27:0] VEC [0:NV-1] = '{
    {4'd2, 1'b0, 7'h4E, 8'h15, 1'b0, 1'b1, 1'b1, 5'h15},  // R2 write
    {4'd3, 1'b1, 7'h4E, 8'h15, 1'b0, 1'b1, 1'b0, 5'h15},  // R3 read back
    {4'd4, 1'b0, 7'h4E, 8'h0A, 1'b1, 1'b1, 1'b0, 5'h15},  // R4 protected
    {4'd5, 1'b0, 7'h4E, 8'h2A, 1'b0, 1'b1, 1'b0, 5'h15},  // R5 bit 5 set
    {4'd5, 1'b0, 7'h4E, 8'h80, 1'b0, 1'b1, 1'b0, 5'h15},  // R5 bit 7 set
    {4'd1, 1'b0, 7'h4F, 8'h03, 1'b0, 1'b0, 1'b0, 5'h15},  // R1 wrong address
    {4'd1, 1'b1, 7'h0E, 8'h00, 1'b0, 1'b0, 1'b0, 5'h15},  // R1 wrong address read
    {4'd2, 1'b0, 7'h4E, 8'h1F, 1'b0, 1'b1, 1'b1, 5'h1F},  // R2 all ones
    {4'd3, 1'b1, 7'h4E, 8'h1F, 1'b0, 1'b1, 1'b0, 5'h1F},  // R3
    {4'd2, 1'b0, 7'h4E, 8'h00, 1'b0, 1'b1, 1'b1, 5'h00},  // R2 clear
    {4'd3, 1'b1, 7'h4E, 8'h00, 1'b0, 1'b1, 1'b0, 5'h00},  // R3
    {4'd2, 1'b0, 7'h4E, 8'h10, 1'b0, 1'b1, 1'b1, 5'h10}   // R2 non-multiplexed bit
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp_m  = 1'b0;
  logic sda_pull;
  logic [4:0] cfg;
  wire  sda_line = sda_m & ~sda_pull;
  int   checks = 0;
  int   fails  = 0;
  int   r10_bad = 0;

  always #2.5 clk = ~clk;

  cfgsw_i2c_target #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .wp_i(wp_m), .cfg_o(cfg)
  );

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(2*Q);
  endtask

  task automatic bit_out(input logic b, input logic glitch);
    sda_m = b;
    if (glitch) begin
      hold(4); scl_m = 1'b1; hold(1); scl_m = 1'b0; hold(5);
    end else begin
      hold(Q);
    end
    scl_m = 1'b1; hold(2*Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    b = sda_line; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic byte_out(input logic [7:0] v, input int glitch_at, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i], (i == glitch_at));
    bit_in(a);
    ack = ~a;
  endtask

  task automatic byte_in(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(1'b1, 1'b0);
  endtask

  task automatic xfer(input logic [6:0] a, input logic rw, input logic [7:0] d,
                      output logic aack, output logic dack, output logic [7:0] rd);
    dack = 1'b0;
    rd   = 8'h00;
    bus_start();
    byte_out({a, rw}, -1, aack);
    if (aack) begin
      if (rw) byte_in(rd);
      else    byte_out(d, -1, dack);
    end
    bus_stop();
  endtask

  always @(negedge clk) begin
    if (rst_n && $rose(sda_pull) && scl_m) r10_bad++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic aa, da;
    logic [7:0] rd;
    hold(10);
    // R6: reset state
    chk(cfg == 5'h00, "R6 cfg after reset", int'(cfg), 0);
    chk(sda_pull == 1'b0, "R6 SDA released after reset", int'(sda_pull), 0);
    rst_n = 1'b1;
    hold(10);

    for (int k = 0; k < NV; k++) begin
      logic [27:0] v;
      string tag;
      v = VEC[k];
      tag = $sformatf("R%0d vector %0d", v[27:24], k);
      wp_m = v[7];
      hold(4);
      xfer(v[22:16], v[23], v[15:8], aa, da, rd);
      chk(aa == v[6], {tag, " address ack"}, int'(aa), int'(v[6]));
      if (v[6] && !v[23]) chk(da == v[5], {tag, " data ack"}, int'(da), int'(v[5]));
      if (v[6] && v[23])  chk(rd == v[15:8], {tag, " read byte"}, int'(rd), int'(v[15:8]));
      chk(cfg == v[4:0], {tag, " cfg"}, int'(cfg), int'(v[4:0]));
      wp_m = 1'b0;
      hold(BUSY + 100);
    end

    // R7: address refused right after a write, accepted after the window
    xfer(7'h4E, 1'b0, 8'h07, aa, da, rd);
    chk(aa && da && cfg == 5'h07, "R7 setup write", int'(cfg), 7);
    xfer(7'h4E, 1'b1, 8'h00, aa, da, rd);
    chk(aa == 1'b0, "R7 no ack while busy", int'(aa), 0);
    hold(BUSY + 100);
    xfer(7'h4E, 1'b1, 8'h00, aa, da, rd);
    chk(aa == 1'b1, "R7 ack after window", int'(aa), 1);
    chk(rd == 8'h07, "R7 read after window", int'(rd), 7);

    // R8: repeated START inside the address byte restarts reception
    bus_start();
    bit_out(1'b1, 1'b0); bit_out(1'b0, 1'b0); bit_out(1'b0, 1'b0); bit_out(1'b1, 1'b0);
    bus_start();
    byte_out({7'h4E, 1'b1}, -1, aa);
    chk(aa == 1'b1, "R8 ack after repeated start", int'(aa), 1);
    if (aa) byte_in(rd);
    bus_stop();
    chk(rd == 8'h07, "R8 read after repeated start", int'(rd), 7);

    // R8: STOP inside a write data byte leaves the register alone
    bus_start();
    byte_out({7'h4E, 1'b0}, -1, aa);
    bit_out(1'b0, 1'b0); bit_out(1'b0, 1'b0); bit_out(1'b0, 1'b0); bit_out(1'b1, 1'b0);
    bus_stop();
    hold(20);
    chk(aa == 1'b1 && cfg == 5'h07, "R8 cfg after mid-byte stop", int'(cfg), 7);

    // R9: one-cycle SCL pulse inside a data bit is not counted
    bus_start();
    byte_out({7'h4E, 1'b0}, -1, aa);
    byte_out(8'h05, 3, da);
    bus_stop();
    chk(aa && da, "R9 data ack with glitch", int'(da), 1);
    chk(cfg == 5'h05, "R9 cfg with glitch", int'(cfg), 5);
    hold(BUSY + 100);

    // R10: SDA pull never asserted while SCL high
    chk(r10_bad == 0, "R10 pull rises with SCL high", r10_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule